// File: doc/BRIEF.md
# Commanded Timer/Counter with Buffered Period

A 16-bit timer/counter that advances on a prescaled count-enable input (`tick`). Software controls it through one control byte. The byte has two write addresses. Writing to the set address turns on the bits written as 1. Writing to the clear address turns off the bits written as 1. Software therefore never needs a read-modify-write. Both addresses read back the same byte.

The control byte holds four items:
- a count direction flag;
- a lock flag that blocks hardware buffer updates;
- a one-shot flag;
- a three-bit command field.

A command in the field waits until the next tick. It then executes and the field returns to zero. The commands are:
- start or retrigger;
- stop;
- forced copy of the double-buffered period and compare values;
- snapshot of the live count into a read-back register.

When counting up, the counter wraps from the period to zero and emits a one-clock overflow pulse. When counting down, it reloads the period at zero and emits an underflow pulse. A wrap is also the hardware moment at which freshly written buffer values are copied into the active registers, unless the lock flag is set.

Top module: `tmr_cmd_counter`

## Requirements
- R1: After reset the control byte reads 0x00 at both 0x04 and 0x05, and the count snapshot (0x0A) reads 0. The active period (0x0B) reads 0xFFFF, both pulse outputs are low and the counter is stopped.
- R2: A write to 0x05 sets each of control bits 2 (one-shot), 1 (lock) and 0 (direction, 1 = down) that is written as 1 and leaves the bits written as 0 unchanged. Bits 4:3 always read 0.
- R3: A write to 0x04 clears each of control bits 2:0 that is written as 1. Command bits written there are ignored. Addresses 0x04 and 0x05 always return the same byte.
- R4: The command field is bits 7:5 of a write to 0x05. Its codes are 1 = retrigger, 2 = stop, 3 = forced update and 4 = snapshot. Writing 0, 5, 6 or 7 leaves the pending field unchanged, and the field never holds a value above 4.
- R5: A pending command executes on the next tick, after which the field reads 0. On that tick the counter does not advance.
- R6: While running with direction 0, each tick increments the count. A tick at count equal to the active period loads 0 and raises `ovf_pulse` for one clock. With direction 1, each tick decrements the count, and a tick at count 0 reloads the active period and raises `unf_pulse` for one clock. The two pulses are never high together.
- R7: With one-shot set, the counter performs a wrap and then stops with the wrapped value held. Further ticks produce no pulse.
- R8: Retrigger loads 0 (up) or the active period (down) and starts counting. Stop halts counting and holds the count.
- R9: A write to 0x08 (period buffer) or 0x09 (compare buffer) marks the buffers valid. A wrap while valid and unlocked copies both buffers to the active period (0x0B) and active compare (0x0C). While locked, a wrap leaves them unchanged, and the copy happens at the first wrap after unlocking.
- R10: The forced update command copies both buffers into the active registers even while locked.
- R11: The count is readable only at 0x0A, which changes only when a snapshot command executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | 16 | Read data (combinational from addr) |
| ovf_pulse | output | 1 | One-clock overflow pulse |
| unf_pulse | output | 1 | One-clock underflow pulse |

## Verification
The assertions expect `tick` and `wr_en` to be synchronous single-clock strobes. They also expect no write to the set address in the same cycle as the tick that retires a pending command. The command-retire property excludes that case explicitly. The bench drives every strobe for exactly one clock from the falling edge. It always separates a command write from its executing tick by at least one clock. It never writes the buffers on a wrap tick, so every copy observed is unambiguous.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_RETRIG = 3'd1,
        CMD_STOP   = 3'd2,
        CMD_UPDATE = 3'd3,
        CMD_SNAP   = 3'd4
    } cmd_e;

    localparam int unsigned ADR_CLR    = 4;
    localparam int unsigned ADR_SET    = 5;
    localparam int unsigned ADR_PERBUF = 8;
    localparam int unsigned ADR_CMPBUF = 9;
    localparam int unsigned ADR_SNAP   = 10;
    localparam int unsigned ADR_PERACT = 11;
    localparam int unsigned ADR_CMPACT = 12;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic [7:0] wbyte,
    output logic [7:0] ctrl_byte,
    output logic       oneshot,
    output logic       lupd,
    output logic       dir,
    output cmd_e       exec_cmd
);
    typedef struct packed {
        cmd_e       cmd;
        logic [2:0] flg;   // {oneshot, lock, dir}
    } ctrl_t;

    ctrl_t q, d;
    logic [2:0] wcmd;

    always_comb begin
        d        = q;
        wcmd     = wbyte[7:5];
        exec_cmd = (tick && q.cmd != CMD_NONE) ? q.cmd : CMD_NONE;
        if (exec_cmd != CMD_NONE)
            d.cmd = CMD_NONE;
        if (set_we) begin
            d.flg = d.flg | wbyte[2:0];
            if (wcmd != 3'd0 && wcmd <= 3'd4)
                d.cmd = cmd_e'(wcmd);
        end
        if (clr_we)
            d.flg = d.flg & ~wbyte[2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cmd: CMD_NONE, flg: 3'b000};
        else        q <= d;
    end

    assign ctrl_byte = {q.cmd, 2'b00, q.flg};
    assign oneshot   = q.flg[2];
    assign lupd      = q.flg[1];
    assign dir       = q.flg[0];

    AST_CMD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cmd != CMD_NONE && !set_we) |=> (q.cmd == CMD_NONE)); // R5
    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (3'(q.cmd) <= 3'd4)); // R4
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((ctrl_byte[2:0] & $past(ctrl_byte[2:0])) == $past(ctrl_byte[2:0]))); // R2
endmodule

// File: rtl/tmr_bufs.sv
module tmr_bufs #(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] RST_PER = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         per_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    input  logic         wrap,
    input  logic         lupd,
    input  logic         force_upd,
    output logic [W-1:0] per_act,
    output logic [W-1:0] cmp_act,
    output logic [W-1:0] per_buf,
    output logic [W-1:0] cmp_buf
);
    typedef struct packed {
        logic [W-1:0] per_b;
        logic [W-1:0] cmp_b;
        logic [W-1:0] per_a;
        logic [W-1:0] cmp_a;
        logic         valid;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (force_upd || (wrap && q.valid && !lupd)) begin
            d.per_a = q.per_b;
            d.cmp_a = q.cmp_b;
            d.valid = 1'b0;
        end
        if (per_we) begin
            d.per_b = wdata;
            d.valid = 1'b1;
        end
        if (cmp_we) begin
            d.cmp_b = wdata;
            d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{per_b: RST_PER, cmp_b: '0, per_a: RST_PER, cmp_a: '0, valid: 1'b0};
        else        q <= d;
    end

    assign per_act = q.per_a;
    assign cmp_act = q.cmp_a;
    assign per_buf = q.per_b;
    assign cmp_buf = q.cmp_b;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && lupd && !force_upd) |=> ($stable(q.per_a) && $stable(q.cmp_a))); // R9
    AST_FORCE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (q.per_a == $past(q.per_b) && q.cmp_a == $past(q.cmp_b))); // R10
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dir,
    input  logic         oneshot,
    input  cmd_e         exec_cmd,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] snap,
    output logic         wrap,
    output logic         ovf,
    output logic         unf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] snap;
        logic         run;
        logic         ovf;
        logic         unf;
    } core_t;

    core_t q, d;

    always_comb begin
        d     = q;
        d.ovf = 1'b0;
        d.unf = 1'b0;
        wrap  = 1'b0;
        case (exec_cmd)
            CMD_RETRIG: begin
                d.cnt = dir ? per_act : '0;
                d.run = 1'b1;
            end
            CMD_STOP: d.run  = 1'b0;
            CMD_SNAP: d.snap = q.cnt;
            default: ;
        endcase
        if (tick && exec_cmd == CMD_NONE && q.run) begin
            if (!dir) begin
                if (q.cnt == per_act) begin
                    d.cnt = '0;
                    d.ovf = 1'b1;
                    wrap  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.cnt == '0) begin
                    d.cnt = per_act;
                    d.unf = 1'b1;
                    wrap  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            if (wrap && oneshot)
                d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cnt: '0, snap: '0, run: 1'b0, ovf: 1'b0, unf: 1'b0};
        else        q <= d;
    end

    assign snap = q.snap;
    assign ovf  = q.ovf;
    assign unf  = q.unf;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ovf && q.unf)); // R6
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && oneshot) |=> !q.run); // R7
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && exec_cmd != CMD_RETRIG) |=> $stable(q.cnt)); // R8
    AST_SNAP_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cmd != CMD_SNAP) |=> $stable(q.snap)); // R11
endmodule

// File: rtl/tmr_cmd_counter.sv
module tmr_cmd_counter
    import tmr_pkg::*;
#(
    parameter int unsigned  W       = 16,
    parameter int unsigned  AW      = 4,
    parameter logic [W-1:0] RST_PER = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          wr_en,
    output logic [W-1:0]  rdata,
    output logic          ovf_pulse,
    output logic          unf_pulse
);
    localparam logic [AW-1:0] A_CLR    = AW'(ADR_CLR);
    localparam logic [AW-1:0] A_SET    = AW'(ADR_SET);
    localparam logic [AW-1:0] A_PERBUF = AW'(ADR_PERBUF);
    localparam logic [AW-1:0] A_CMPBUF = AW'(ADR_CMPBUF);
    localparam logic [AW-1:0] A_SNAP   = AW'(ADR_SNAP);
    localparam logic [AW-1:0] A_PERACT = AW'(ADR_PERACT);
    localparam logic [AW-1:0] A_CMPACT = AW'(ADR_CMPACT);

    logic [7:0]   ctrl_byte;
    logic         oneshot, lupd, dir, wrap;
    cmd_e         exec_cmd;
    logic [W-1:0] per_act, cmp_act, per_buf, cmp_buf, snap;

    tmr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .set_we    (wr_en && addr == A_SET),
        .clr_we    (wr_en && addr == A_CLR),
        .wbyte     (wdata[7:0]),
        .ctrl_byte (ctrl_byte),
        .oneshot   (oneshot),
        .lupd      (lupd),
        .dir       (dir),
        .exec_cmd  (exec_cmd)
    );

    tmr_bufs #(.W(W), .RST_PER(RST_PER)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_we    (wr_en && addr == A_PERBUF),
        .cmp_we    (wr_en && addr == A_CMPBUF),
        .wdata     (wdata),
        .wrap      (wrap),
        .lupd      (lupd),
        .force_upd (exec_cmd == CMD_UPDATE),
        .per_act   (per_act),
        .cmp_act   (cmp_act),
        .per_buf   (per_buf),
        .cmp_buf   (cmp_buf)
    );

    tmr_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .dir      (dir),
        .oneshot  (oneshot),
        .exec_cmd (exec_cmd),
        .per_act  (per_act),
        .snap     (snap),
        .wrap     (wrap),
        .ovf      (ovf_pulse),
        .unf      (unf_pulse)
    );

    always_comb begin
        case (addr)
            A_CLR, A_SET: rdata = {{(W-8){1'b0}}, ctrl_byte};
            A_PERBUF:     rdata = per_buf;
            A_CMPBUF:     rdata = cmp_buf;
            A_SNAP:       rdata = snap;
            A_PERACT:     rdata = per_act;
            A_CMPACT:     rdata = cmp_act;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: tb/tmr_cmd_counter_bench.sv
module tmr_cmd_counter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [15:0] rdata;
    logic        ovf_pulse, unf_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmd_counter u_tmr_cmd_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rdata(rdata), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] dv);
        @(negedge clk); addr = a; wdata = dv; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] dv);
        addr = a; #1; dv = rdata;
    endtask

    task automatic cmd(input logic [2:0] c);
        wr(4'h5, {8'h00, c, 5'b00000});
        tk();
    endtask

    task automatic count_is(input string req, input logic [15:0] exp);
        logic [15:0] v;
        cmd(3'd4);
        rd(4'hA, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'h5, v); chk("R1 set addr", v, 16'h0000);
        rd(4'h4, v); chk("R1 clr addr", v, 16'h0000);
        rd(4'hA, v); chk("R1 snapshot", v, 16'h0000);
        rd(4'hB, v); chk("R1 period", v, 16'hFFFF);
        chk("R1 pulses", {14'd0, ovf_pulse, unf_pulse}, 16'h0000);
    endtask

    task automatic t_setclr();
        logic [15:0] v;
        wr(4'h5, 16'h0007); rd(4'h5, v); chk("R2 set all", v, 16'h0007);
        wr(4'h5, 16'h0000); rd(4'h5, v); chk("R2 zero keeps", v, 16'h0007);
        wr(4'h5, 16'h0018); rd(4'h5, v); chk("R2 bits4:3", v, 16'h0007);
        wr(4'h4, 16'h0002); rd(4'h4, v); chk("R3 clear lock", v, 16'h0005);
        rd(4'h5, v); chk("R3 mirror", v, 16'h0005);
        wr(4'h5, 16'h0020); wr(4'h4, 16'h00E0);
        rd(4'h4, v); chk("R3 clr ignores cmd", v, 16'h0025);
        tk(); rd(4'h5, v); chk("R5 cmd retires", v, 16'h0005);
        wr(4'h4, 16'h0007); cmd(3'd2);
    endtask

    task automatic t_illegal();
        logic [15:0] v;
        wr(4'h5, 16'h00A0); rd(4'h5, v); chk("R4 code5 ignored", v, 16'h0000);
        wr(4'h5, 16'h0040); wr(4'h5, 16'h00E0);
        rd(4'h5, v); chk("R4 code7 keeps pending", v, 16'h0040);
        wr(4'h5, 16'h0000); rd(4'h5, v); chk("R4 code0 keeps pending", v, 16'h0040);
        tk(); rd(4'h5, v); chk("R5 stop retired", v, 16'h0000);
    endtask

    task automatic t_up();
        logic [15:0] v;
        wr(4'h8, 16'd3); cmd(3'd3);
        rd(4'hB, v); chk("R10 forced period", v, 16'd3);
        cmd(3'd1); ticks(3);
        chk("R6 no early ovf", {15'd0, ovf_pulse}, 16'd0);
        count_is("R6 up count / R5 no advance", 16'd3);
        tk(); chk("R6 ovf pulse", {15'd0, ovf_pulse}, 16'd1);
        @(negedge clk); chk("R6 ovf one clock", {15'd0, ovf_pulse}, 16'd0);
        count_is("R6 wrap to zero", 16'd0);
        cmd(3'd2);
    endtask

    task automatic t_down();
        wr(4'h5, 16'h0001); cmd(3'd1);
        count_is("R8 down retrigger", 16'd3);
        ticks(3); count_is("R6 down count", 16'd0);
        tk(); chk("R6 unf pulse", {14'd0, ovf_pulse, unf_pulse}, 16'd1);
        count_is("R6 reload", 16'd3);
        cmd(3'd2); wr(4'h4, 16'h0001);
    endtask

    task automatic t_oneshot();
        wr(4'h5, 16'h0005); cmd(3'd1); ticks(4);
        chk("R7 first unf", {15'd0, unf_pulse}, 16'd1);
        tk(); chk("R7 no pulse", {15'd0, unf_pulse}, 16'd0);
        tk(); chk("R7 no pulse 2", {15'd0, unf_pulse}, 16'd0);
        count_is("R7 held", 16'd3);
        wr(4'h4, 16'h0005);
    endtask

    task automatic t_stop();
        cmd(3'd1); ticks(2); cmd(3'd2); ticks(2);
        count_is("R8 stop holds", 16'd2);
        cmd(3'd1); count_is("R8 retrigger zero", 16'd0);
        tk(); count_is("R8 restarted", 16'd1);
        cmd(3'd2);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(4'h8, 16'd5); wr(4'h9, 16'h1234); wr(4'h5, 16'h0002);
        cmd(3'd1); ticks(4);
        chk("R9 wrap while locked", {15'd0, ovf_pulse}, 16'd1);
        rd(4'hB, v); chk("R9 lock period", v, 16'd3);
        rd(4'hC, v); chk("R9 lock compare", v, 16'd0);
        wr(4'h4, 16'h0002); ticks(4);
        rd(4'hB, v); chk("R9 period after unlock", v, 16'd5);
        rd(4'hC, v); chk("R9 compare after unlock", v, 16'h1234);
        ticks(5); chk("R9 no ovf below new period", {15'd0, ovf_pulse}, 16'd0);
        count_is("R9 counts to new period", 16'd5);
        tk(); chk("R9 ovf at new period", {15'd0, ovf_pulse}, 16'd1);
        cmd(3'd2);
    endtask

    task automatic t_force();
        logic [15:0] v;
        wr(4'h5, 16'h0002); wr(4'h8, 16'd7); cmd(3'd3);
        rd(4'hB, v); chk("R10 forced under lock", v, 16'd7);
        wr(4'h4, 16'h0002);
    endtask

    task automatic t_snap();
        logic [15:0] v;
        cmd(3'd1); cmd(3'd4); ticks(2);
        rd(4'hA, v); chk("R11 snapshot stale", v, 16'd0);
        count_is("R11 snapshot refreshed", 16'd2);
        cmd(3'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_illegal();
        t_up();
        t_down();
        t_oneshot();
        t_stop();
        t_lock();
        t_force();
        t_snap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule